// File: doc/BRIEF.md
# Cable Activity Wake Controller

This block decides when the line drivers and the charge pump of a multi-channel serial-line transceiver are powered. It watches one "input idle" flag per receiver, raised by an analog detector when nothing drives that line. It combines them with a shutdown request (active low), a force-on request and a receiver output enable (active low). A shared idle timer and a wake timer turn the driver/pump enable off and on. A separate status flag with asymmetric timing tracks cable activity in every mode.

All delays are set in nanoseconds and turned into clock cycles from the clock frequency parameter. Counter widths follow from those cycle counts. Every control input passes through a two-stage synchronizer before it is used. A parameter selects the output-enable scheme. In the two-channel scheme, the receiver output enable decides whether the receiver outputs are driven. In the multi-channel scheme, shutdown gates the normal receiver outputs and one monitor receiver output is always driven.

Top module: `line_wake_ctrl`

## Requirements
- R1: While reset is high, drv_en, status and rx_oe are 0. mon_oe is 1 in the multi-channel scheme (HAS_MONITOR=1) and 0 in the two-channel scheme (HAS_MONITOR=0).
- R2: shdn_n low forces drv_en to 0 on the third rising edge after the change, whatever force_on and the idle flags are.
- R3: With shdn_n high and force_on high, drv_en is 1 from the third rising edge onward, whether or not any receiver is active.
- R4: In auto mode (shdn_n high, force_on low), drv_en falls on the (IDLE+3)th rising edge after all rx_idle bits become 1. Any idle bit going to 0, even for one cycle, restarts that count. IDLE = CLK_MHZ*IDLE_NS/1000.
- R5: In auto mode with drv_en low, drv_en rises on the (WAKE+3)th rising edge after at least one rx_idle bit goes to 0 and stays there. Time spent with shdn_n low does not count. WAKE = CLK_MHZ*WAKE_NS/1000.
- R6: status rises on the (RISE+3)th rising edge after any rx_idle bit goes to 0 and stays there. Activity shorter than that leaves status at 0. RISE = CLK_MHZ*STS_RISE_NS/1000.
- R7: status falls on the (FALL+3)th rising edge after all rx_idle bits become 1. FALL = CLK_MHZ*STS_FALL_NS/1000.
- R8: status follows cable activity with the timing of R6 and R7 in every mode, including while shdn_n is low or force_on is high.
- R9: In the two-channel scheme, rx_oe equals the inverse of rx_en_n three rising edges after rx_en_n changes, whatever shdn_n is, and mon_oe stays 0.
- R10: In the multi-channel scheme, rx_oe equals shdn_n three rising edges after shdn_n changes, rx_en_n has no effect on it, and mon_oe stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_idle | input | NUM_RX | Per-receiver idle flag, 1 = no cable activity |
| shdn_n | input | 1 | Shutdown request, active low |
| force_on | input | 1 | Keeps drivers powered and bypasses the auto timers |
| rx_en_n | input | 1 | Receiver output enable, active low (two-channel scheme) |
| drv_en | output | 1 | Driver and charge pump enable |
| status | output | 1 | Cable activity flag |
| rx_oe | output | 1 | Output enable for the normal receiver outputs |
| mon_oe | output | 1 | Output enable for the always-on monitor receiver |

## Verification
Every result is due a fixed number of rising edges after its stimulus. Mode and enable changes show at the third edge. Idle, wake, status-rise and status-fall results show at the timer length plus three edges, because two synchronizer stages, the count and the output register all lie on the path. For each exact-timing case, the bench changes inputs on a falling edge and samples the outputs on a falling edge one edge before the due edge, where the old value must still hold, and again at the due edge. The stimulus table uses waits that clear each window by a safe margin. The one-cycle activity pulse checks that the idle count restarts and that status does not rise.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic shdn_n;
        logic force_on;
        logic rx_en_n;
    } mode_t;

    localparam mode_t MODE_RESET = '{shdn_n: 1'b0, force_on: 1'b0, rx_en_n: 1'b1};

    function automatic int ns_to_cycles(input int clk_mhz, input int ns);
        int c;
        c = (clk_mhz * ns) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int count_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lwc_sync.sv
module lwc_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lwc_timer.sv
module lwc_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int           W   = lwc_pkg::count_bits(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);

    // R4: the count saturates at its limit and never wraps
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM);

    // R4: a cycle without the run condition restarts the window
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> !done);
endmodule

// File: rtl/lwc_power_fsm.sv
module lwc_power_fsm #(
    parameter int IDLE_CYC = 4,
    parameter int WAKE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic shdn_n_s,
    input  logic force_on_s,
    input  logic any_active,
    output logic drv_en
);
    import lwc_pkg::*;

    pwr_state_e state, state_nx;
    logic       idle_done;
    logic       wake_done;

    lwc_timer #(.LIMIT(IDLE_CYC)) u_idle_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (!any_active),
        .done (idle_done)
    );

    lwc_timer #(.LIMIT(WAKE_CYC)) u_wake_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (any_active && shdn_n_s),
        .done (wake_done)
    );

    always_comb begin
        state_nx = state;
        if (!shdn_n_s) begin
            state_nx = PWR_OFF;
        end else if (force_on_s) begin
            state_nx = PWR_ON;
        end else if (state == PWR_ON && idle_done) begin
            state_nx = PWR_OFF;
        end else if (state == PWR_OFF && wake_done) begin
            state_nx = PWR_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PWR_OFF;
        else     state <= state_nx;
    end

    assign drv_en = (state == PWR_ON);

    // R2: shutdown beats every other request
    a_r2_shutdown_wins: assert property (@(posedge clk) disable iff (rst)
        !shdn_n_s |=> !drv_en);

    // R3: force-on keeps the drivers powered
    a_r3_force_holds: assert property (@(posedge clk) disable iff (rst)
        (shdn_n_s && force_on_s) |=> drv_en);

    // R5: power-up only by force-on or an expired wake window
    a_r5_wake_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> ($past(force_on_s) || $past(wake_done)));

    // R4: power-down only by shutdown or an expired idle window
    a_r4_sleep_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> (!$past(shdn_n_s) || $past(idle_done)));
endmodule

// File: rtl/lwc_status.sv
module lwc_status #(
    parameter int RISE_CYC = 2,
    parameter int FALL_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic any_active,
    output logic status
);
    logic rise_done;
    logic fall_done;

    lwc_timer #(.LIMIT(RISE_CYC)) u_rise_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (any_active),
        .done (rise_done)
    );

    lwc_timer #(.LIMIT(FALL_CYC)) u_fall_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (!any_active),
        .done (fall_done)
    );

    always_ff @(posedge clk) begin
        if (rst)            status <= 1'b0;
        else if (rise_done) status <= 1'b1;
        else if (fall_done) status <= 1'b0;
    end

    // R6: status rises only after a full activity window
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(rise_done));

    // R7: status falls only after a full quiet window
    a_r7_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(status) |-> $past(fall_done));
endmodule

// File: rtl/line_wake_ctrl.sv
module line_wake_ctrl #(
    parameter int NUM_RX      = 5,
    parameter int CLK_MHZ     = 125,
    parameter bit HAS_MONITOR = 1'b1,
    parameter int IDLE_NS     = 100000,
    parameter int WAKE_NS     = 200000,
    parameter int STS_RISE_NS = 500,
    parameter int STS_FALL_NS = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_RX-1:0] rx_idle,
    input  logic              shdn_n,
    input  logic              force_on,
    input  logic              rx_en_n,
    output logic              drv_en,
    output logic              status,
    output logic              rx_oe,
    output logic              mon_oe
);
    import lwc_pkg::*;

    localparam int IDLE_CYC = ns_to_cycles(CLK_MHZ, IDLE_NS);
    localparam int WAKE_CYC = ns_to_cycles(CLK_MHZ, WAKE_NS);
    localparam int RISE_CYC = ns_to_cycles(CLK_MHZ, STS_RISE_NS);
    localparam int FALL_CYC = ns_to_cycles(CLK_MHZ, STS_FALL_NS);

    mode_t             mode_raw;
    mode_t             mode_s;
    logic [NUM_RX-1:0] rx_idle_s;
    logic              any_active;
    logic              rx_oe_q;

    assign mode_raw = '{shdn_n: shdn_n, force_on: force_on, rx_en_n: rx_en_n};

    lwc_sync #(.W(3), .INIT(MODE_RESET)) u_mode_sync (
        .clk (clk),
        .rst (rst),
        .d   (mode_raw),
        .q   (mode_s)
    );

    lwc_sync #(.W(NUM_RX), .INIT({NUM_RX{1'b1}})) u_idle_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_idle),
        .q   (rx_idle_s)
    );

    assign any_active = !(&rx_idle_s);

    lwc_power_fsm #(.IDLE_CYC(IDLE_CYC), .WAKE_CYC(WAKE_CYC)) u_power (
        .clk        (clk),
        .rst        (rst),
        .shdn_n_s   (mode_s.shdn_n),
        .force_on_s (mode_s.force_on),
        .any_active (any_active),
        .drv_en     (drv_en)
    );

    lwc_status #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_status (
        .clk        (clk),
        .rst        (rst),
        .any_active (any_active),
        .status     (status)
    );

    generate
        if (HAS_MONITOR) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) rx_oe_q <= 1'b0;
                else     rx_oe_q <= mode_s.shdn_n;
            end
            assign mon_oe = 1'b1;

            // R10: shutdown takes the normal receiver outputs off the bus
            a_r10_shutdown_gates_rx: assert property (@(posedge clk) disable iff (rst)
                !mode_s.shdn_n |=> !rx_oe);

            // R10: the receiver enable alone never moves rx_oe
            a_r10_enable_ignored: assert property (@(posedge clk) disable iff (rst)
                ($changed(mode_s.rx_en_n) && $stable(mode_s.shdn_n)) |=> $stable(rx_oe));
        end else begin : g_two
            always_ff @(posedge clk) begin
                if (rst) rx_oe_q <= 1'b0;
                else     rx_oe_q <= !mode_s.rx_en_n;
            end
            assign mon_oe = 1'b0;

            // R9: a disabled receiver enable releases the outputs in any mode
            a_r9_enable_gates_rx: assert property (@(posedge clk) disable iff (rst)
                mode_s.rx_en_n |=> !rx_oe);
        end
    endgenerate

    assign rx_oe = rx_oe_q;
endmodule

// File: tb/test_line_wake_ctrl.sv
`timescale 1ns/1ps
module test_line_wake_ctrl;

    // Latencies from R4..R7 with bench timings at 125 MHz:
    // IDLE 100, WAKE 200, RISE 10, FALL 50 cycles, plus 3 edges.
    localparam int IDLE_LAT = 103;
    localparam int WAKE_LAT = 203;
    localparam int RISE_LAT = 13;
    localparam int FALL_LAT = 53;
    localparam logic [4:0] ALL_IDLE = 5'b11111;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] rx_idle;
    logic       shdn_n, force_on, rx_en_n;
    logic       drv_en, status, rx_oe, mon_oe;
    logic       drv_en2, status2, rx_oe2, mon_oe2;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    line_wake_ctrl #(
        .NUM_RX(5), .CLK_MHZ(125), .HAS_MONITOR(1'b1),
        .IDLE_NS(800), .WAKE_NS(1600), .STS_RISE_NS(80), .STS_FALL_NS(400)
    ) i_line_wake_ctrl (
        .clk(clk), .rst(rst), .rx_idle(rx_idle), .shdn_n(shdn_n),
        .force_on(force_on), .rx_en_n(rx_en_n), .drv_en(drv_en),
        .status(status), .rx_oe(rx_oe), .mon_oe(mon_oe)
    );

    line_wake_ctrl #(
        .NUM_RX(2), .CLK_MHZ(125), .HAS_MONITOR(1'b0),
        .IDLE_NS(800), .WAKE_NS(1600), .STS_RISE_NS(80), .STS_FALL_NS(400)
    ) i_line_wake_ctrl_two (
        .clk(clk), .rst(rst), .rx_idle(rx_idle[1:0]), .shdn_n(shdn_n),
        .force_on(force_on), .rx_en_n(rx_en_n), .drv_en(drv_en2),
        .status(status2), .rx_oe(rx_oe2), .mon_oe(mon_oe2)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {shdn_n, force_on, rx_en_n, rx_idle[4:0], wait[9:0], drv, status, rx_oe}
    localparam logic [20:0] VEC [12] = '{
        {1'b1, 1'b1, 1'b0, 5'b11111, 10'd5,   3'b101},
        {1'b1, 1'b1, 1'b0, 5'b11110, 10'd20,  3'b111},
        {1'b0, 1'b1, 1'b0, 5'b11110, 10'd5,   3'b010},
        {1'b0, 1'b0, 1'b0, 5'b11111, 10'd60,  3'b000},
        {1'b1, 1'b0, 1'b0, 5'b11111, 10'd5,   3'b001},
        {1'b1, 1'b0, 1'b0, 5'b10111, 10'd210, 3'b111},
        {1'b1, 1'b0, 1'b0, 5'b11111, 10'd60,  3'b101},
        {1'b1, 1'b0, 1'b0, 5'b11111, 10'd50,  3'b001},
        {1'b1, 1'b0, 1'b1, 5'b01111, 10'd100, 3'b011},
        {1'b0, 1'b0, 1'b1, 5'b01111, 10'd300, 3'b010},
        {1'b1, 1'b0, 1'b1, 5'b01111, 10'd5,   3'b011},
        {1'b1, 1'b0, 1'b1, 5'b01111, 10'd210, 3'b111}
    };

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; shdn_n = 1'b0; force_on = 1'b0; rx_en_n = 1'b1; rx_idle = ALL_IDLE;
        adv(4);
        chk("R1 drv_en",        drv_en,  1'b0);
        chk("R1 status",        status,  1'b0);
        chk("R1 rx_oe",         rx_oe,   1'b0);
        chk("R1 mon_oe multi",  mon_oe,  1'b1);
        chk("R1 rx_oe two",     rx_oe2,  1'b0);
        chk("R1 mon_oe two",    mon_oe2, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            shdn_n   = VEC[i][20];
            force_on = VEC[i][19];
            rx_en_n  = VEC[i][18];
            rx_idle  = VEC[i][17:13];
            adv(int'(VEC[i][12:3]));
            chk($sformatf("R4 R5 table row %0d drv_en", i), drv_en, VEC[i][2]);
            chk($sformatf("R8 table row %0d status", i),    status, VEC[i][1]);
            chk($sformatf("R10 table row %0d rx_oe", i),    rx_oe,  VEC[i][0]);
        end

        // R9: two-channel enable timing, three edges
        rx_en_n = 1'b0;
        adv(5);
        chk("R9 rx_oe two enabled", rx_oe2, 1'b1);
        chk("R10 rx_oe multi unaffected", rx_oe, 1'b1);
        rx_en_n = 1'b1;
        adv(2);
        chk("R9 rx_oe two before edge 3", rx_oe2, 1'b1);
        adv(1);
        chk("R9 rx_oe two at edge 3", rx_oe2, 1'b0);
        chk("R9 mon_oe two", mon_oe2, 1'b0);
        chk("R10 rx_oe multi ignores enable", rx_oe, 1'b1);

        // R7 and R4 exact edges from powered auto mode with activity
        rx_idle = ALL_IDLE;
        adv(FALL_LAT - 1);
        chk("R7 status before fall", status, 1'b1);
        adv(1);
        chk("R7 status at fall", status, 1'b0);
        adv(IDLE_LAT - FALL_LAT - 1);
        chk("R4 drv_en before idle timeout", drv_en, 1'b1);
        adv(1);
        chk("R4 drv_en at idle timeout", drv_en, 1'b0);

        // R6 and R5 exact edges
        rx_idle = 5'b11110;
        adv(RISE_LAT - 1);
        chk("R6 status before rise", status, 1'b0);
        adv(1);
        chk("R6 status at rise", status, 1'b1);
        adv(WAKE_LAT - RISE_LAT - 1);
        chk("R5 drv_en before wake", drv_en, 1'b0);
        adv(1);
        chk("R5 drv_en at wake", drv_en, 1'b1);

        // R4 restart by a one-cycle activity pulse; R6 short activity
        rx_idle = ALL_IDLE;
        adv(80);
        chk("R4 drv_en mid window", drv_en, 1'b1);
        chk("R7 status quiet", status, 1'b0);
        rx_idle = 5'b11101;
        adv(1);
        rx_idle = ALL_IDLE;
        adv(IDLE_LAT - 1);
        chk("R4 drv_en restarted window", drv_en, 1'b1);
        chk("R6 status ignores short pulse", status, 1'b0);
        adv(1);
        chk("R4 drv_en after restarted window", drv_en, 1'b0);

        // R3 and R2 exact edge, R8 status during shutdown
        force_on = 1'b1;
        rx_idle  = 5'b11110;
        adv(20);
        chk("R3 drv_en forced on", drv_en, 1'b1);
        chk("R8 status forced mode", status, 1'b1);
        shdn_n = 1'b0;
        adv(2);
        chk("R2 drv_en before edge 3", drv_en, 1'b1);
        adv(1);
        chk("R2 drv_en at edge 3", drv_en, 1'b0);
        chk("R10 rx_oe in shutdown", rx_oe, 1'b0);
        chk("R10 mon_oe in shutdown", mon_oe, 1'b1);
        rx_idle = ALL_IDLE;
        adv(FALL_LAT - 1);
        chk("R8 status in shutdown before fall", status, 1'b1);
        adv(1);
        chk("R8 status in shutdown at fall", status, 1'b0);
        rx_en_n = 1'b0;
        adv(5);
        chk("R9 rx_oe two in shutdown", rx_oe2, 1'b1);

        // R3: force-on without any activity stays powered
        shdn_n = 1'b1;
        adv(3);
        chk("R3 drv_en at edge 3", drv_en, 1'b1);
        adv(300);
        chk("R3 drv_en held without activity", drv_en, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule